// File: doc/BRIEF.md
# Dual-Edge Event Interrupt Aggregator

This block watches a set of asynchronous event lines (up to 32) and turns their transitions into a single active-low interrupt request. Each line can be armed separately for rising edges, falling edges or both. An armed edge sets a pending bit, which stays set until the host collects it. The interrupt request stays low while any pending bit is set.

The host reaches the block through a small byte-wide command port. A command starts with a one-cycle `cmd_start` pulse. `cmd_rd` picks between loading the edge masks and collecting the pending report. Both payloads are byte-interleaved and begin with the low byte. Even byte positions carry rising-edge data and odd positions carry falling-edge data, so byte 2g holds rising bits 8g..8g+7 and byte 2g+1 holds falling bits 8g..8g+7. A host that has armed only low-numbered lines can therefore stop after the first few bytes. Each byte it reads is cleared as it is returned, and bytes it does not read keep their pending bits.

Top module: `edge_irq_agg`

## Requirements
- R1: After reset `irq_n` is high, `rd_valid` is low, both edge masks are zero, and a read returns all-zero bytes.
- R2: A mask load takes one argument byte per `arg_valid` cycle. Byte 2g is the rising mask of lines 8g..8g+7 and byte 2g+1 is the falling mask of the same lines. The masks change only when the last byte (byte 7 for 32 lines) is accepted, so a load with fewer bytes leaves the old masks in force.
- R3: A 0-to-1 transition on a line with its rising enable set sets that line's rising pending bit.
- R4: A 1-to-0 transition on a line with its falling enable set sets that line's falling pending bit.
- R5: A line with both edges enabled that toggles up and then down before a read reports both bits in that same read.
- R6: A transition on a line whose enable for that edge direction is clear sets no pending bit and leaves `irq_n` unchanged.
- R7: `irq_n` is low exactly while at least one pending bit is set.
- R8: On the cycle after a read request (`rd_req` inside a read command), `rd_valid` pulses and `rd_byte` holds report byte k, where k counts the reads since `cmd_start`. Even k gives rising bits 8(k/2).., and odd k gives falling bits.
- R9: A read clears only the pending bits of the byte it returned. Bytes that were not read stay pending and keep `irq_n` low.
- R10: An edge that is latched in the same cycle that its byte is cleared by a read stays pending. That read returns the old byte, and the next read returns the new bit.
- R11: Loading all-zero masks clears all pending bits, and after that no transition can pull `irq_n` low. More generally, a mask load drops pending bits whose enable it clears.
- R12: After all report bytes have been read, further `rd_req` cycles produce no `rd_valid` until the next `cmd_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_LINES | Asynchronous event lines |
| cmd_start | input | 1 | Starts a command and resets the byte index |
| cmd_rd | input | 1 | With `cmd_start`: 1 = read-and-clear report, 0 = mask load |
| arg_valid | input | 1 | Mask argument byte strobe |
| arg_byte | input | 8 | Mask argument byte |
| rd_req | input | 1 | Report byte request |
| rd_valid | output | 1 | Report byte valid, one cycle after the request |
| rd_byte | output | 8 | Report byte |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench aims at the cycle where a read clears byte 0 while a new edge on line 0 lands in the same byte. A design that gave the clear priority would lose that edge, and one that merged the edge into the returned data would report it twice. Truncated reads of random length check that unread bytes survive. A design that cleared the whole report on any read would drop `irq_n` too early. Mask loads cut short after seven bytes must leave the old masks in force, and a design that committed bytes one at a time would arm lines half-way through a load. Swapping the rising and falling positions, or reading past the last byte, would show up as wrong report bytes or a spurious `rd_valid`.

// File: rtl/eia_pkg.sv
package eia_pkg;
   localparam int BYTE_W = 8;
   localparam int MAX_LINES = 32;

   typedef enum logic {
      OP_MASK = 1'b0,
      OP_READ = 1'b1
   } eia_op_e;

   function automatic int grp_count(input int lines);
      return (lines + BYTE_W - 1) / BYTE_W;
   endfunction

   function automatic int pad_width(input int lines);
      return BYTE_W * grp_count(lines);
   endfunction

   function automatic int byte_count(input int lines);
      return 2 * grp_count(lines);
   endfunction
endpackage

// File: rtl/eia_sync.sv
module eia_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("eia_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      end else begin
         chain[0] <= async_i;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/eia_edge_bank.sv
module eia_edge_bank #(
   parameter int NUM_LINES = 32,
   parameter int PADW      = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] smp_i,
   input  logic [PADW-1:0]      en_r_nx,
   input  logic [PADW-1:0]      en_f_nx,
   input  logic [PADW-1:0]      clr_r,
   input  logic [PADW-1:0]      clr_f,
   output logic [PADW-1:0]      pend_r,
   output logic [PADW-1:0]      pend_f
);
   logic [NUM_LINES-1:0] prev_q;
   logic [PADW-1:0]      ev_r, ev_f;

   always_comb begin
      ev_r = '0;
      ev_f = '0;
      ev_r[NUM_LINES-1:0] = smp_i & ~prev_q;
      ev_f[NUM_LINES-1:0] = prev_q & ~smp_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         pend_r <= '0;
         pend_f <= '0;
      end else begin
         prev_q <= smp_i;
         // a fresh edge wins over a clear of the same bit
         pend_r <= ((pend_r & ~clr_r) | ev_r) & en_r_nx;
         pend_f <= ((pend_f & ~clr_f) | ev_f) & en_f_nx;
      end
   end
endmodule

// File: rtl/eia_cmd_port.sv
module eia_cmd_port
   import eia_pkg::*;
#(
   parameter int NUM_LINES = 32,
   parameter int PADW      = pad_width(NUM_LINES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmd_start,
   input  logic            cmd_rd,
   input  logic            arg_valid,
   input  logic [7:0]      arg_byte,
   input  logic            rd_req,
   input  logic [PADW-1:0] pend_r,
   input  logic [PADW-1:0] pend_f,
   output logic [PADW-1:0] en_r,
   output logic [PADW-1:0] en_f,
   output logic [PADW-1:0] en_r_nx,
   output logic [PADW-1:0] en_f_nx,
   output logic [PADW-1:0] clr_r,
   output logic [PADW-1:0] clr_f,
   output logic            commit,
   output logic            rd_fire,
   output logic            rd_valid,
   output logic [7:0]      rd_byte
);
   localparam int NGRP  = grp_count(NUM_LINES);
   localparam int NBYTE = byte_count(NUM_LINES);
   localparam int IDXW  = $clog2(NBYTE + 1);
   localparam logic [PADW-1:0] LMASK = {PADW{1'b1}} >> (PADW - NUM_LINES);

   eia_op_e               op_q;
   logic [IDXW-1:0]       idx_q;
   logic [8*NBYTE-1:0]    shadow_q;
   logic [8*NBYTE-1:0]    shadow_full;
   logic [PADW-1:0]       new_r, new_f;
   logic                  active, arg_ok;
   int                    grp;

   assign active  = idx_q < IDXW'(NBYTE);
   assign arg_ok  = arg_valid && !cmd_start && op_q == OP_MASK && active;
   assign rd_fire = rd_req && !cmd_start && op_q == OP_READ && active;
   assign commit  = arg_ok && idx_q == IDXW'(NBYTE - 1);
   assign grp     = int'(idx_q >> 1);

   always_comb begin
      shadow_full = shadow_q;
      shadow_full[8*(NBYTE-1) +: 8] = arg_byte;
   end

   generate
      for (genvar g = 0; g < NGRP; g++) begin : g_grp
         assign new_r[8*g +: 8] = shadow_full[16*g +: 8];
         assign new_f[8*g +: 8] = shadow_full[16*g + 8 +: 8];
         assign clr_r[8*g +: 8] = {8{rd_fire && idx_q == IDXW'(2*g)}};
         assign clr_f[8*g +: 8] = {8{rd_fire && idx_q == IDXW'(2*g + 1)}};
      end
   endgenerate

   assign en_r_nx = commit ? (new_r & LMASK) : en_r;
   assign en_f_nx = commit ? (new_f & LMASK) : en_f;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q     <= OP_MASK;
         idx_q    <= IDXW'(NBYTE);
         shadow_q <= '0;
         en_r     <= '0;
         en_f     <= '0;
         rd_valid <= 1'b0;
         rd_byte  <= '0;
      end else begin
         en_r     <= en_r_nx;
         en_f     <= en_f_nx;
         rd_valid <= rd_fire;
         if (cmd_start) begin
            op_q  <= cmd_rd ? OP_READ : OP_MASK;
            idx_q <= '0;
         end else if (arg_ok || rd_fire) begin
            idx_q <= idx_q + 1'b1;
         end
         if (arg_ok) shadow_q[8*idx_q +: 8] <= arg_byte;
         if (rd_fire) rd_byte <= idx_q[0] ? pend_f[8*grp +: 8] : pend_r[8*grp +: 8];
      end
   end
endmodule

// File: rtl/edge_irq_agg.sv
module edge_irq_agg
   import eia_pkg::*;
#(
   parameter int NUM_LINES   = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] evt_i,
   input  logic                 cmd_start,
   input  logic                 cmd_rd,
   input  logic                 arg_valid,
   input  logic [7:0]           arg_byte,
   input  logic                 rd_req,
   output logic                 rd_valid,
   output logic [7:0]           rd_byte,
   output logic                 irq_n
);
   localparam int PADW = pad_width(NUM_LINES);

   generate
      if (NUM_LINES < 1 || NUM_LINES > MAX_LINES) begin : g_bad_lines
         $error("edge_irq_agg: NUM_LINES out of range");
      end
   endgenerate

   logic [NUM_LINES-1:0] smp;
   logic [PADW-1:0]      pend_r, pend_f, en_r, en_f, en_r_nx, en_f_nx;
   logic [PADW-1:0]      clr_r, clr_f;
   logic                 commit, rd_fire;

   eia_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(evt_i), .sync_o(smp)
   );

   eia_edge_bank #(.NUM_LINES(NUM_LINES), .PADW(PADW)) u_bank (
      .clk(clk), .rst_n(rst_n), .smp_i(smp),
      .en_r_nx(en_r_nx), .en_f_nx(en_f_nx),
      .clr_r(clr_r), .clr_f(clr_f),
      .pend_r(pend_r), .pend_f(pend_f)
   );

   eia_cmd_port #(.NUM_LINES(NUM_LINES), .PADW(PADW)) u_port (
      .clk(clk), .rst_n(rst_n),
      .cmd_start(cmd_start), .cmd_rd(cmd_rd),
      .arg_valid(arg_valid), .arg_byte(arg_byte), .rd_req(rd_req),
      .pend_r(pend_r), .pend_f(pend_f),
      .en_r(en_r), .en_f(en_f), .en_r_nx(en_r_nx), .en_f_nx(en_f_nx),
      .clr_r(clr_r), .clr_f(clr_f),
      .commit(commit), .rd_fire(rd_fire),
      .rd_valid(rd_valid), .rd_byte(rd_byte)
   );

   assign irq_n = ~(|pend_r | |pend_f);
endmodule

// File: rtl/edge_irq_agg_chk.sv
module edge_irq_agg_chk #(
   parameter int PADW = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            irq_n,
   input logic            rd_valid,
   input logic            rd_fire,
   input logic            commit,
   input logic [PADW-1:0] pend_r,
   input logic [PADW-1:0] pend_f,
   input logic [PADW-1:0] en_r,
   input logic [PADW-1:0] en_f
);
   // R11
   zero_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_r == '0 && en_f == '0) |-> irq_n);

   // R6
   pend_within_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_r & ~en_r) == '0) && ((pend_f & ~en_f) == '0));

   // R9
   pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_fire && !commit) |=>
         ((pend_r & $past(pend_r)) == $past(pend_r)) &&
         ((pend_f & $past(pend_f)) == $past(pend_f)));

   // R8
   rd_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_fire |=> rd_valid);

   // R12
   no_stray_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_fire |=> !rd_valid);
endmodule

bind edge_irq_agg edge_irq_agg_chk #(.PADW(PADW)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .rd_valid(rd_valid),
   .rd_fire(rd_fire), .commit(commit),
   .pend_r(pend_r), .pend_f(pend_f), .en_r(en_r), .en_f(en_f)
);

// File: tb/edge_irq_agg_tb.sv
module edge_irq_agg_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] evt = '0;
   logic        cmd_start = 1'b0, cmd_rd = 1'b0, arg_valid = 1'b0, rd_req = 1'b0;
   logic [7:0]  arg_byte = '0;
   logic        rd_valid, irq_n;
   logic [7:0]  rd_byte;

   int nchk = 0;
   int nerr = 0;

   logic [31:0] er = '0, ef = '0, mr = '0, mf = '0, cur = '0;

   always #5 clk = ~clk;

   edge_irq_agg #(.NUM_LINES(32)) u_dut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .cmd_start(cmd_start),
      .cmd_rd(cmd_rd), .arg_valid(arg_valid), .arg_byte(arg_byte),
      .rd_req(rd_req), .rd_valid(rd_valid), .rd_byte(rd_byte), .irq_n(irq_n)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_byte(input int k);
      return (k % 2 == 0) ? mr[8*(k/2) +: 8] : mf[8*(k/2) +: 8];
   endfunction

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   endtask

   task automatic drive_evt(input logic [31:0] nv);
      @(negedge clk);
      evt = nv;
      mr |= er & nv & ~cur;
      mf |= ef & cur & ~nv;
      cur = nv;
      repeat (4) @(negedge clk);
   endtask

   task automatic set_mask(input logic [31:0] r, input logic [31:0] f, input int nb);
      @(negedge clk);
      cmd_start = 1'b1; cmd_rd = 1'b0;
      @(negedge clk);
      cmd_start = 1'b0;
      for (int k = 0; k < nb; k++) begin
         arg_valid = 1'b1;
         arg_byte = (k % 2 == 0) ? r[8*(k/2) +: 8] : f[8*(k/2) +: 8];
         @(negedge clk);
      end
      arg_valid = 1'b0;
      if (nb == 8) begin
         er = r; ef = f; mr &= r; mf &= f;
      end
      @(negedge clk);
   endtask

   task automatic read_rep(input int len, input string req);
      @(negedge clk);
      cmd_start = 1'b1; cmd_rd = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
      for (int k = 0; k < len; k++) begin
         rd_req = 1'b1;
         @(negedge clk);
         chk({req, " rd_valid"}, 32'(rd_valid), 32'd1);
         chk({req, " byte"}, 32'(rd_byte), 32'(exp_byte(k)));
         if (k % 2 == 0) mr[8*(k/2) +: 8] = '0;
         else            mf[8*(k/2) +: 8] = '0;
      end
      rd_req = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 irq_n", 32'(irq_n), 32'd1);
      chk("R1 rd_valid", 32'(rd_valid), 32'd0);
      drive_evt(32'hFFFF_FFFF);
      drive_evt(32'h0);
      chk("R1 R6 no enable irq_n", 32'(irq_n), 32'd1);
      read_rep(8, "R1 zero report");

      // R2 R3 R4 interleaved mask, rising on group 0, falling on group 1
      set_mask(32'h0000_00FF, 32'h0000_FF00, 8);
      drive_evt(32'h0000_0101);
      chk("R3 irq_n low", 32'(irq_n), 32'd0);
      drive_evt(32'h0);
      chk("R7 irq_n low", 32'(irq_n), 32'd0);
      read_rep(4, "R2 R3 R4 R8 layout");
      chk("R7 irq_n after clear", 32'(irq_n), 32'd1);

      // R2 short load keeps old masks
      set_mask(32'hFFFF_FFFF, 32'hFFFF_FFFF, 7);
      drive_evt(32'h8000_0000);
      drive_evt(32'h0);
      chk("R2 R6 short load ignored", 32'(irq_n), 32'd1);

      // R5 both edges in one read
      set_mask(32'hFFFF_FFFF, 32'hFFFF_FFFF, 8);
      drive_evt(32'h0001_0000);
      drive_evt(32'h0);
      read_rep(6, "R5 both edges");

      // R9 partial read leaves high bytes pending
      drive_evt(32'h0100_0001);
      read_rep(2, "R9 partial");
      chk("R9 irq_n still low", 32'(irq_n), 32'd0);
      read_rep(8, "R9 rest");
      chk("R9 irq_n released", 32'(irq_n), 32'd1);

      // R12 reads past the end
      @(negedge clk);
      rd_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
      chk("R12 no valid past end", 32'(rd_valid), 32'd0);

      // R10 edge latched in the same cycle its byte is cleared
      drive_evt(32'h0000_0002);
      @(negedge clk);
      cmd_start = 1'b1; cmd_rd = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
      evt = 32'h0000_0003;
      @(negedge clk);
      @(negedge clk);
      rd_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
      chk("R10 returns old byte", 32'(rd_byte), 32'h02);
      cur = 32'h3; mr = 32'h1; mf = '0;
      @(negedge clk);
      chk("R10 irq_n kept", 32'(irq_n), 32'd0);
      read_rep(1, "R10 new bit");

      // R11 zero mask drops pending and blocks irq
      drive_evt(32'h0);
      chk("R11 pending before", 32'(irq_n), 32'd0);
      set_mask(32'h0, 32'h0, 8);
      chk("R11 cleared", 32'(irq_n), 32'd1);
      drive_evt(32'hA5A5_5A5A);
      drive_evt(32'h0);
      chk("R11 quiet", 32'(irq_n), 32'd1);
      read_rep(8, "R11 empty");

      // random stimulus
      for (int it = 0; it < 40; it++) begin
         if (it % 8 == 0) set_mask($urandom(), $urandom(), 8);
         drive_evt($urandom());
         drive_evt(cur ^ $urandom());
         chk("R7 random irq_n", 32'(irq_n), 32'(((mr | mf) == '0)));
         read_rep(1 + ($urandom() % 8), "R8 R9 random");
      end
      read_rep(8, "R9 drain");
      chk("R7 final irq_n", 32'(irq_n), 32'd1);
      summary();
   end
endmodule